// File: doc/BRIEF.md
# Register Window Call/Return Controller

This block keeps the control state of a rotating register window: the index of the physical quad of four registers that is currently seen as logical registers 0 to 3 (the window base), and a mask with one bit per physical quad that marks the quads where a live call frame begins (the window-start mask). It changes this state in response to decoded operation strobes from the instruction pipeline. The register data itself and any spill or fill trap detection are kept outside the block.

A windowed call does not move the window. It records a two-bit quad increment, which is 1, 2 or 3 for calls that hide 4, 8 or 12 registers. That same increment is also presented as the two bits to be placed at the top of the saved return address. The later entry operation applies the recorded increment to the window base. It also marks the new frame in the window-start mask and produces the callee's stack pointer, which is the caller's stack pointer minus an immediate frame size.

A return rotates the window back by the two bits taken from the return address and unmarks the frame that is returning. The return is discarded when an external residency check reports that the target frame has been spilled. An explicit rotate adds a signed quad count to the window base. All arithmetic on the window base wraps modulo the quad count.

Top module: `regwin_ctrl`

## Requirements
- R1: After synchronous reset the window base is 0, the window-start mask has only bit 0 set, and the recorded call increment, return-address bits and entry stack pointer are all 0.
- R2: A call strobe with increment value k (1, 2 or 3) sets both the recorded call increment and the return-address bits output to k on the next cycle. It leaves the window base and the window-start mask unchanged.
- R3: An entry strobe sets the window base to the old base plus the recorded call increment, modulo NQUADS, on the next cycle.
- R4: An entry strobe sets the entry stack pointer output to the old stack pointer input minus the frame-size input, modulo 2^XLEN, on the next cycle.
- R5: An entry strobe sets the window-start bit at the new window base and leaves all other mask bits unchanged.
- R6: A return strobe, when the miss flag is low, sets the window base to the old base minus the return-address bits, modulo NQUADS. It also clears the window-start bit at the old (returning) base and leaves all other mask bits unchanged.
- R7: A return strobe with the miss flag high leaves the window base and the window-start mask unchanged.
- R8: A rotate strobe adds the two's-complement RW-bit amount to the window base, modulo NQUADS. A positive amount raises the base, so after a rotate by +1 the quad formerly seen as logical registers 4 to 7 becomes registers 0 to 3. The window-start mask is unchanged.
- R9: Window base arithmetic wraps. An entry with increment 2 from base NQUADS-1 gives base 1, and a rotate by -1 from base 0 gives base NQUADS-1.
- R10: In a cycle with no strobe, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_call | input | 1 | Windowed call strobe |
| call_inc_in | input | 2 | Quad increment of the call (1, 2 or 3) |
| op_entry | input | 1 | Entry strobe |
| sp_in | input | XLEN | Caller's stack pointer (old logical register 1) |
| frame_size | input | FW | Immediate frame size subtracted on entry |
| op_ret | input | 1 | Return strobe |
| ret_bits | input | 2 | Top two bits of the return address |
| ret_miss | input | 1 | Target frame not resident; suppresses the return |
| op_rot | input | 1 | Explicit rotate strobe |
| rot_amt | input | RW | Signed rotate amount in quads |
| win_base | output | log2(NQUADS) | Current window base |
| win_start | output | NQUADS | Window-start mask |
| call_inc | output | 2 | Recorded call increment |
| ra_bits | output | 2 | Bits to insert at the top of the return address |
| entry_sp | output | XLEN | New stack pointer produced by entry |

## Verification
Some properties are checked on every cycle: how each strobe moves the window base (entry, return and rotate), the single mask bit that entry sets and return clears, that a call and a missed return leave the state alone, and that the entry stack pointer is a difference. None of these properties can show that a whole chain of operations stays consistent. The bench's scenarios cover that: nested calls followed by returns that restore the earlier base and mask, wrap-around at both ends of the quad range, rotates in both directions, and outputs holding through idle cycles.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef logic [1:0] quad_inc_t;
  localparam quad_inc_t INC_NONE = 2'd0;
endpackage

// File: rtl/regwin_base.sv
module regwin_base #(
  parameter int NQUADS = 16,
  parameter int RW     = 4,
  localparam int QW    = $clog2(NQUADS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    do_entry,
  input  logic                    do_ret,
  input  logic                    do_rot,
  input  regwin_pkg::quad_inc_t   inc_q,
  input  logic [1:0]              ret_bits,
  input  logic [RW-1:0]           rot_amt,
  output logic [QW-1:0]           base_q,
  output logic [QW-1:0]           base_nxt
);
  logic [QW+RW-1:0] rot_wide;
  logic [QW-1:0]    rot_q;
  logic [QW-1:0]    inc_w;
  logic [QW-1:0]    ret_w;

  assign rot_wide = {{QW{rot_amt[RW-1]}}, rot_amt};
  assign rot_q    = rot_wide[QW-1:0];
  assign inc_w    = {{(QW-2){1'b0}}, inc_q};
  assign ret_w    = {{(QW-2){1'b0}}, ret_bits};

  always_comb begin
    base_nxt = base_q;
    if (do_entry)    base_nxt = base_q + inc_w;
    else if (do_ret) base_nxt = base_q - ret_w;
    else if (do_rot) base_nxt = base_q + rot_q;
  end

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else     base_q <= base_nxt;
  end

  // R3 / R9: entry advances by the recorded increment with wrap
  assert_entry_adv_R3: assert property (@(posedge clk) disable iff (rst)
    do_entry |=> (QW'(base_q - $past(base_q)) == {{(QW-2){1'b0}}, $past(inc_q)}));
  // R6: return moves back by the return-address bits
  assert_ret_back_R6: assert property (@(posedge clk) disable iff (rst)
    do_ret |=> (QW'($past(base_q) - base_q) == {{(QW-2){1'b0}}, $past(ret_bits)}));
  // R8: rotate moves by the sign-extended amount
  assert_rot_move_R8: assert property (@(posedge clk) disable iff (rst)
    (do_rot && !do_entry && !do_ret) |=>
      (QW'(base_q - $past(base_q)) == $past(rot_q)));
  // R10: no strobe, base holds
  assert_base_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!do_entry && !do_ret && !do_rot) |=> $stable(base_q));
endmodule

// File: rtl/regwin_start.sv
module regwin_start #(
  parameter int NQUADS = 16,
  localparam int QW    = $clog2(NQUADS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              do_entry,
  input  logic              do_ret,
  input  logic [QW-1:0]     base_q,
  input  logic [QW-1:0]     base_nxt,
  output logic [NQUADS-1:0] ws_q
);
  logic [NQUADS-1:0] ws_nxt;

  for (genvar g = 0; g < NQUADS; g++) begin : g_bit
    always_comb begin
      ws_nxt[g] = ws_q[g];
      if (do_entry && (base_nxt == QW'(g)))  ws_nxt[g] = 1'b1;
      else if (do_ret && (base_q == QW'(g))) ws_nxt[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ws_q <= NQUADS'(1);
    else     ws_q <= ws_nxt;
  end

  // R5: entry changes at most one mask bit, and that bit is then set
  assert_entry_mark_R5: assert property (@(posedge clk) disable iff (rst)
    do_entry |=> ($countones(ws_q ^ $past(ws_q)) <= 1) && ws_q[base_q]);
  // R6: return changes at most one mask bit, and leaves none newly set
  assert_ret_unmark_R6: assert property (@(posedge clk) disable iff (rst)
    do_ret |=> ($countones(ws_q ^ $past(ws_q)) <= 1) &&
               ((ws_q & ~$past(ws_q)) == '0));
  // R10 / R2 / R8: without entry or return the mask holds
  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!do_entry && !do_ret) |=> $stable(ws_q));
endmodule

// File: rtl/regwin_frame.sv
module regwin_frame #(
  parameter int XLEN = 32,
  parameter int FW   = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  do_call,
  input  regwin_pkg::quad_inc_t inc_in,
  input  logic                  do_entry,
  input  logic [XLEN-1:0]       sp_in,
  input  logic [FW-1:0]         frame_size,
  output regwin_pkg::quad_inc_t inc_q,
  output logic [1:0]            ra_q,
  output logic [XLEN-1:0]       sp_q
);
  logic [XLEN-1:0] size_w;
  assign size_w = {{(XLEN-FW){1'b0}}, frame_size};

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q <= regwin_pkg::INC_NONE;
      ra_q  <= 2'd0;
      sp_q  <= '0;
    end else begin
      if (do_call) begin
        inc_q <= inc_in;
        ra_q  <= inc_in;
      end
      if (do_entry) sp_q <= sp_in - size_w;
    end
  end

  // R2: both copies of the increment follow the call
  assert_call_copy_R2: assert property (@(posedge clk) disable iff (rst)
    do_call |=> (inc_q == $past(inc_in)) && (ra_q == inc_q));
  // R4: entry stack pointer plus frame size restores the input
  assert_entry_sp_R4: assert property (@(posedge clk) disable iff (rst)
    do_entry |=> (XLEN'(sp_q + {{(XLEN-FW){1'b0}}, $past(frame_size)}) == $past(sp_in)));
  // R10: idle holds
  assert_frame_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!do_call && !do_entry) |=> $stable(inc_q) && $stable(ra_q) && $stable(sp_q));
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl #(
  parameter int NQUADS = 16,
  parameter int XLEN   = 32,
  parameter int FW     = 12,
  parameter int RW     = 4,
  localparam int QW    = $clog2(NQUADS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_call,
  input  logic [1:0]        call_inc_in,
  input  logic              op_entry,
  input  logic [XLEN-1:0]   sp_in,
  input  logic [FW-1:0]     frame_size,
  input  logic              op_ret,
  input  logic [1:0]        ret_bits,
  input  logic              ret_miss,
  input  logic              op_rot,
  input  logic [RW-1:0]     rot_amt,
  output logic [QW-1:0]     win_base,
  output logic [NQUADS-1:0] win_start,
  output logic [1:0]        call_inc,
  output logic [1:0]        ra_bits,
  output logic [XLEN-1:0]   entry_sp
);
  logic          do_ret;
  logic [QW-1:0] base_nxt;

  assign do_ret = op_ret && !ret_miss;

  regwin_base #(.NQUADS(NQUADS), .RW(RW)) u_base (
    .clk(clk), .rst(rst), .do_entry(op_entry), .do_ret(do_ret), .do_rot(op_rot),
    .inc_q(call_inc), .ret_bits(ret_bits), .rot_amt(rot_amt),
    .base_q(win_base), .base_nxt(base_nxt));

  regwin_start #(.NQUADS(NQUADS)) u_start (
    .clk(clk), .rst(rst), .do_entry(op_entry), .do_ret(do_ret),
    .base_q(win_base), .base_nxt(base_nxt), .ws_q(win_start));

  regwin_frame #(.XLEN(XLEN), .FW(FW)) u_frame (
    .clk(clk), .rst(rst), .do_call(op_call), .inc_in(call_inc_in),
    .do_entry(op_entry), .sp_in(sp_in), .frame_size(frame_size),
    .inc_q(call_inc), .ra_q(ra_bits), .sp_q(entry_sp));

  // operation strobes are mutually exclusive
  assert_one_op_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({op_call, op_entry, op_ret, op_rot}));
  // R7: a missed return leaves base and mask alone
  assert_miss_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (op_ret && ret_miss) |=> $stable(win_base) && $stable(win_start));
  // R1: reset state
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (win_base == '0) && (win_start == NQUADS'(1)) && (call_inc == 2'd0));
endmodule

// File: tb/regwin_ctrl_tb_top.sv
`timescale 1ns/1ps
module regwin_ctrl_tb_top;
  localparam int NQ = 16;
  localparam int XL = 32;
  localparam int FW = 12;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_call = 0, op_entry = 0, op_ret = 0, op_rot = 0, ret_miss = 0;
  logic [1:0] call_inc_in = 0, ret_bits = 0;
  logic [XL-1:0] sp_in = 0;
  logic [FW-1:0] frame_size = 0;
  logic [RW-1:0] rot_amt = 0;
  logic [3:0] win_base;
  logic [NQ-1:0] win_start;
  logic [1:0] call_inc, ra_bits;
  logic [XL-1:0] entry_sp;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [3:0] e_base;
  logic [NQ-1:0] e_ws;
  logic [1:0] e_inc;

  always #4 clk = ~clk;

  regwin_ctrl #(.NQUADS(NQ), .XLEN(XL), .FW(FW), .RW(RW)) dut_i (
    .clk(clk), .rst(rst), .op_call(op_call), .call_inc_in(call_inc_in),
    .op_entry(op_entry), .sp_in(sp_in), .frame_size(frame_size),
    .op_ret(op_ret), .ret_bits(ret_bits), .ret_miss(ret_miss),
    .op_rot(op_rot), .rot_amt(rot_amt), .win_base(win_base),
    .win_start(win_start), .call_inc(call_inc), .ra_bits(ra_bits),
    .entry_sp(entry_sp));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    op_call = 0; op_entry = 0; op_ret = 0; op_rot = 0; ret_miss = 0;
  endtask

  task automatic chk_state(string tag);
    chk({tag, " base"}, 32'(win_base), 32'(e_base));
    chk({tag, " mask"}, 32'(win_start), 32'(e_ws));
  endtask

  task automatic do_call(logic [1:0] k);
    op_call = 1; call_inc_in = k; step();
    e_inc = k;
    chk("R2 call_inc", 32'(call_inc), 32'(k));
    chk("R2 ra_bits", 32'(ra_bits), 32'(k));
    chk_state("R2");
  endtask

  task automatic do_entry(logic [31:0] sp, logic [11:0] sz);
    op_entry = 1; sp_in = sp; frame_size = sz; step();
    e_base = e_base + 4'(e_inc);
    e_ws[e_base] = 1'b1;
    chk("R4 sp", entry_sp, sp - 32'(sz));
    chk_state("R3 R5 entry");
  endtask

  task automatic do_ret(logic [1:0] b, logic miss);
    op_ret = 1; ret_bits = b; ret_miss = miss; step();
    if (!miss) begin
      e_ws[e_base] = 1'b0;
      e_base = e_base - 4'(b);
      chk_state("R6 ret");
    end else chk_state("R7 miss");
  endtask

  task automatic do_rot(logic [3:0] a);
    op_rot = 1; rot_amt = a; step();
    e_base = e_base + a;
    chk_state("R8 rot");
  endtask

  task automatic t_reset();
    e_base = 0; e_ws = 1; e_inc = 0;
    chk_state("R1");
    chk("R1 inc", 32'(call_inc), 0);
    chk("R1 ra", 32'(ra_bits), 0);
    chk("R1 sp", entry_sp, 0);
  endtask

  task automatic t_nest();
    do_call(2'd1); do_entry(32'h1000, 12'h020);   // base 1
    do_call(2'd3); do_entry(32'h0FE0, 12'h040);   // base 4
    do_call(2'd2); do_entry(32'h0005, 12'h010);   // base 6, sp wraps
    chk("R9 sp wrap", entry_sp, 32'hFFFF_FFF5);
    do_ret(2'd2, 1'b1);                           // suppressed
    do_ret(2'd2, 1'b0); do_ret(2'd3, 1'b0);
    chk("R6 back to 1", 32'(win_base), 1);
    chk("R6 mask 0,1", 32'(win_start), 32'h3);
    do_ret(2'd1, 1'b0);
  endtask

  task automatic t_rot_wrap();
    do_rot(4'd1);
    chk("R8 plus one", 32'(win_base), 1);
    do_rot(4'hE);                                 // -2 -> 15
    chk("R9 neg wrap", 32'(win_base), 15);
    do_call(2'd2); do_entry(32'h2000, 12'h0);
    chk("R9 entry wrap", 32'(win_base), 1);
  endtask

  task automatic t_idle();
    repeat (3) step();
    chk_state("R10 idle");
    chk("R10 inc", 32'(call_inc), 2);
    chk("R10 sp", entry_sp, 32'h2000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_nest();
    t_rot_wrap();
    t_idle();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule